// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block holds the address windows of four DRAM chip selects and resolves a physical address against them. Software programs each window through a 32-bit register port. Every window has two words: a base word at byte offset 8·n and a size word at byte offset 8·n + 4. A window covers a whole number of 16 MB units. Its start comes from base bits 31:24 together with four upper address bits (35:32). Its length is the size field plus one, counted in 16 MB units.

A lookup request presents a 36-bit address. One cycle later the block reports four things. It says whether an enabled window claims the address and which chip select owns it. It gives the bus attribute a device must issue to reach that chip select: a one-cold nibble, plus a coherency flag when that option is built in. It also gives the compact index of the window in the device-visible list. A window is device-visible only when it is enabled and its upper base bits are all zero. A separate output counts how many such windows exist. Windows that start above 4 GB still decode for the processor but are left out of that list.

Top module: `csw_decoder`

## Requirements
- R1: Register layout. Byte offset bits 4:2 select the word: window = offset/8, with the base word at 8·n and the size word at 8·n + 4. Offset bits 1:0 are ignored. The base word keeps bits 31:24 (address bits 31:24) and bits 3:0 (address bits 35:32). The size word keeps bit 0 (enable), bits 4:2 (chip-select number field) and bits 31:24 (size minus one in 16 MB units). Every other bit reads 0. Offsets of 32 and above read 0, and writes to them are ignored.
- R2: After reset every register reads 0, dev_count is 0, and a lookup misses.
- R3: A window matches when it is enabled and base ≤ address < base + (size field + 1)·16 MB. Base is taken as {base[3:0], base[31:24]}·16 MB over the full 36-bit address.
- R4: When several windows match, the lowest window index is reported in res_cs.
- R5: On a miss, res_cs, res_attr, res_slot and res_dev are all 0.
- R6: On a hit, res_attr[3:0] is 4'hF with bit res_cs cleared. res_attr[4] equals the COHERENT parameter, and res_attr[7:5] is 0.
- R7: dev_count equals the number of windows that are enabled and have base bits 3:0 equal to zero.
- R8: On a hit, res_dev is 1 when the matched window is device-visible. res_slot is then the number of device-visible windows with a lower index.
- R9: res_valid is high exactly one cycle after lk_valid. While lk_valid is low, the result fields keep their last values.
- R10: A window with nonzero upper base bits still matches addresses at or above 4 GB, but it reports res_dev = 0.
- R11: A lookup issued in the same cycle as a register write is resolved against the configuration from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 36 | Physical address to resolve |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | An enabled window claimed the address |
| res_cs | output | 2 | Index of the winning window |
| res_attr | output | 8 | Bus attribute for the winning chip select |
| res_slot | output | 2 | Compact device-visible index of the winner |
| res_dev | output | 1 | Winner is device-visible |
| dev_count | output | 3 | Number of device-visible windows |

## Verification
The bench probes the last 16 MB unit inside a window and the first unit past it. An off-by-one in the end comparison would claim the second address or drop the first. It builds overlapping windows to check that the lowest index wins; inverted priority would report the higher chip select and the wrong attribute. Windows with upper base bits set are placed among visible ones. A design that ignored those bits would overcount dev_count, shift the compact slot numbers, or match addresses below 4 GB. A write and a lookup issued together show whether the decoder reads stale or fresh configuration.

// File: rtl/csw_pkg.sv
package csw_pkg;

    // Register field positions (the register format is software-visible)
    localparam int BASE_LO_MSB = 31;
    localparam int BASE_LO_LSB = 24;
    localparam int BASE_HI_MSB = 3;
    localparam int SIZE_EN_BIT = 0;
    localparam int SIZE_CS_MSB = 4;
    localparam int SIZE_CS_LSB = 2;

    typedef struct packed {
        logic       en;
        logic [2:0] csf;
        logic [7:0] szm1;
        logic [7:0] blo;
        logic [3:0] bhi;
    } win_cfg_t;

    function automatic logic [31:0] base_word(input win_cfg_t c);
        return {c.blo, 20'd0, c.bhi};
    endfunction

    function automatic logic [31:0] size_word(input win_cfg_t c);
        return {c.szm1, 19'd0, c.csf, 1'b0, c.en};
    endfunction

endpackage

// File: rtl/csw_regfile.sv
module csw_regfile
    import csw_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int REG_AW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output win_cfg_t          cfg [NUM_WIN]
);
    localparam int WORD_W = REG_AW - 2;

    logic [WORD_W-1:0] word;
    logic [WORD_W-2:0] win_idx;
    logic              is_size;
    logic              in_range;

    assign word     = addr[REG_AW-1:2];
    assign win_idx  = word[WORD_W-1:1];
    assign is_size  = word[0];
    assign in_range = (int'(win_idx) < NUM_WIN);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[g] <= '0;
            end else if (wr && in_range && int'(win_idx) == g) begin
                if (is_size) begin
                    cfg[g].en   <= wdata[SIZE_EN_BIT];
                    cfg[g].csf  <= wdata[SIZE_CS_MSB:SIZE_CS_LSB];
                    cfg[g].szm1 <= wdata[31:24];
                end else begin
                    cfg[g].blo  <= wdata[BASE_LO_MSB:BASE_LO_LSB];
                    cfg[g].bhi  <= wdata[BASE_HI_MSB:0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (in_range && int'(win_idx) == i)
                rdata = is_size ? size_word(cfg[i]) : base_word(cfg[i]);
        end
    end

endmodule

// File: rtl/csw_match.sv
module csw_match #(
    parameter int UNIT_W = 12
) (
    input  logic              en,
    input  logic [7:0]        szm1,
    input  logic [7:0]        blo,
    input  logic [3:0]        bhi,
    input  logic [UNIT_W-1:0] addr_unit,
    output logic              hit,
    output logic              visible
);
    logic [UNIT_W:0] base_u;
    logic [UNIT_W:0] end_u;
    logic [UNIT_W:0] a_u;

    assign base_u  = {1'b0, bhi, blo};
    assign end_u   = base_u + {{(UNIT_W-7){1'b0}}, szm1} + 1'b1;
    assign a_u     = {1'b0, addr_unit};
    assign hit     = en && (a_u >= base_u) && (a_u < end_u);
    assign visible = en && (bhi == 4'd0);

endmodule

// File: rtl/csw_select.sv
module csw_select #(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2,
    parameter int CNT_W   = 3
) (
    input  logic [NUM_WIN-1:0] hits,
    input  logic [NUM_WIN-1:0] vis,
    output logic               any_hit,
    output logic [IDX_W-1:0]   win,
    output logic [IDX_W-1:0]   slot,
    output logic               win_vis,
    output logic [CNT_W-1:0]   vis_count
);
    always_comb begin
        any_hit = 1'b0;
        win     = '0;
        slot    = '0;
        win_vis = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                win     = IDX_W'(i);
                win_vis = vis[i];
            end
        end
        for (int j = 0; j < NUM_WIN; j++) begin
            if (any_hit && win_vis && vis[j] && (j < int'(win)))
                slot = slot + 1'b1;
        end
    end

    always_comb begin
        vis_count = '0;
        for (int k = 0; k < NUM_WIN; k++)
            vis_count = vis_count + CNT_W'(vis[k]);
    end

endmodule

// File: rtl/csw_decoder.sv
module csw_decoder
    import csw_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int ADDR_W    = 36,
    parameter int GRAN_LOG2 = 24,
    parameter bit COHERENT  = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_valid,
    input  logic [35:0] lk_addr,
    output logic        res_valid,
    output logic        res_hit,
    output logic [1:0]  res_cs,
    output logic [7:0]  res_attr,
    output logic [1:0]  res_slot,
    output logic        res_dev,
    output logic [2:0]  dev_count
);
    localparam int UNIT_W = ADDR_W - GRAN_LOG2;
    localparam int IDX_W  = $clog2(NUM_WIN);
    localparam int CNT_W  = $clog2(NUM_WIN + 1);

    win_cfg_t           cfg [NUM_WIN];
    logic [NUM_WIN-1:0] hits;
    logic [NUM_WIN-1:0] vis;
    logic               any_hit;
    logic [IDX_W-1:0]   win;
    logic [IDX_W-1:0]   slot;
    logic               win_vis;
    logic [CNT_W-1:0]   vis_count;
    logic [7:0]         attr_n;

    csw_regfile #(.NUM_WIN(NUM_WIN), .REG_AW(6)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        csw_match #(.UNIT_W(UNIT_W)) u_match (
            .en        (cfg[g].en),
            .szm1      (cfg[g].szm1),
            .blo       (cfg[g].blo),
            .bhi       (cfg[g].bhi),
            .addr_unit (lk_addr[ADDR_W-1:GRAN_LOG2]),
            .hit       (hits[g]),
            .visible   (vis[g])
        );
    end

    csw_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_sel (
        .hits      (hits),
        .vis       (vis),
        .any_hit   (any_hit),
        .win       (win),
        .slot      (slot),
        .win_vis   (win_vis),
        .vis_count (vis_count)
    );

    always_comb begin
        attr_n = 8'h0F & ~(8'h01 << win);
        if (COHERENT)
            attr_n = attr_n | 8'h10;
        if (!any_hit)
            attr_n = 8'h00;
    end

    assign dev_count = vis_count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_cs    <= '0;
            res_attr  <= '0;
            res_slot  <= '0;
            res_dev   <= 1'b0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_hit  <= any_hit;
                res_cs   <= win;
                res_attr <= attr_n;
                res_slot <= slot;
                res_dev  <= any_hit && win_vis;
            end
        end
    end

endmodule

// File: rtl/csw_decoder_chk.sv
module csw_decoder_chk #(
    parameter bit COHERENT = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic        res_valid,
    input logic        res_hit,
    input logic [1:0]  res_cs,
    input logic [7:0]  res_attr,
    input logic [1:0]  res_slot,
    input logic        res_dev,
    input logic [2:0]  dev_count
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R9
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> $stable(res_hit) && $stable(res_cs) && $stable(res_attr)); // R9
    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_hit |-> res_cs == 2'd0 && res_attr == 8'd0
                                  && res_slot == 2'd0 && !res_dev); // R5
    AST_ONE_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_hit |-> $countones(res_attr[3:0]) == 3
                                 && !res_attr[res_cs]); // R6
    AST_COHERENT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_hit |-> res_attr[4] == COHERENT && res_attr[7:5] == 3'd0); // R6
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_count <= 3'd4); // R7
    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_dev |-> res_slot <= res_cs && res_hit); // R8
endmodule

bind csw_decoder csw_decoder_chk #(.COHERENT(COHERENT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_cs    (res_cs),
    .res_attr  (res_attr),
    .res_slot  (res_slot),
    .res_dev   (res_dev),
    .dev_count (dev_count)
);

// File: tb/sim_csw_decoder.sv
`timescale 1ns/1ps
module sim_csw_decoder;
    localparam bit COH = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [35:0] lk_addr = '0;
    logic        res_valid, res_hit, res_dev;
    logic [1:0]  res_cs, res_slot;
    logic [7:0]  res_attr;
    logic [2:0]  dev_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mbase [4];
    logic [31:0] msize [4];

    always #4 clk = ~clk;

    csw_decoder #(.COHERENT(COH)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit),
        .res_cs(res_cs), .res_attr(res_attr), .res_slot(res_slot),
        .res_dev(res_dev), .dev_count(dev_count)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit m_hit(input int i, input logic [35:0] a);
        logic [12:0] b, e, u;
        b = {1'b0, mbase[i][3:0], mbase[i][31:24]};
        e = b + {5'd0, msize[i][31:24]} + 13'd1;
        u = {1'b0, a[35:24]};
        return msize[i][0] && u >= b && u < e;
    endfunction

    function automatic bit m_vis(input int i);
        return msize[i][0] && mbase[i][3:0] == 4'd0;
    endfunction

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < 4; i++) c += m_vis(i);
        return c;
    endfunction

    // Starts and ends at a falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a < 6'd32) begin
            if (a[2]) msize[a[4:3]] = d & 32'hFF00001D;
            else      mbase[a[4:3]] = d & 32'hFF00000F;
        end
    endtask

    task automatic set_win(input int i, input logic [3:0] hi, input logic [7:0] lo,
                           input logic [7:0] sz, input bit en);
        wr(6'(i * 8), {lo, 20'd0, hi});
        wr(6'(i * 8 + 4), {sz, 19'd0, 3'(i), 1'b0, en});
    endtask

    task automatic look(input string req, input logic [35:0] a);
        int w; bit h; bit v; int s;
        logic [7:0] at;
        w = 0; h = 0; v = 0; s = 0;
        for (int i = 3; i >= 0; i--) if (m_hit(i, a)) begin h = 1; w = i; end
        if (h) begin
            v = m_vis(w);
            if (v) for (int j = 0; j < w; j++) s += m_vis(j);
        end
        at = h ? ((8'h0F & ~(8'h01 << w)) | (COH ? 8'h10 : 8'h00)) : 8'h00;
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " valid"}, res_valid, 1);
        chk({req, " hit"}, res_hit, h);
        chk({req, " cs"}, res_cs, h ? w : 0);
        chk({req, " attr"}, res_attr, at);
        chk({req, " slot"}, res_slot, s);
        chk({req, " dev"}, res_dev, v);
    endtask

    task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        for (int i = 0; i < 4; i++) begin mbase[i] = 0; msize[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state
        for (int a = 0; a < 32; a += 4) rd("R2 readback", 6'(a), 32'd0);
        chk("R2 dev_count", dev_count, 0);
        look("R2 lookup", 36'h0_0000_0000);

        // R1: masking and unmapped offsets
        wr(6'd0, 32'hFFFF_FFFF);
        rd("R1 base mask", 6'd0, 32'hFF00_000F);
        wr(6'd4, 32'hFFFF_FFFE);
        rd("R1 size mask", 6'd4, 32'hFF00_001C);
        rd("R1 low offset bits ignored", 6'd7, 32'hFF00_001C);
        wr(6'd40, 32'hFFFF_FFFF);
        rd("R1 unmapped read", 6'd40, 32'd0);
        for (int a = 8; a < 32; a += 4) rd("R1 unmapped write no effect", 6'(a), 32'd0);
        wr(6'd0, 0); wr(6'd4, 0);

        // R3 boundaries: window 1 at 0x0300_0000, 2 units
        set_win(1, 4'h0, 8'h03, 8'h01, 1'b1);
        look("R3 below base", 36'h0_02FF_FFFF);
        look("R3 at base", 36'h0_0300_0000);
        look("R3 last byte", 36'h0_04FF_FFFF);
        look("R3 past end", 36'h0_0500_0000);
        // disabled window does not hit
        set_win(0, 4'h0, 8'h03, 8'h00, 1'b0);
        look("R3 disabled", 36'h0_0300_0000);

        // R4 overlap: window 0 enabled overlapping window 1
        set_win(0, 4'h0, 8'h04, 8'h00, 1'b1);
        look("R4 lowest wins", 36'h0_0400_0000);
        look("R4 only w1", 36'h0_0300_0000);

        // R10/R8/R7: window 2 above 4 GB, window 3 visible
        set_win(2, 4'h1, 8'h00, 8'h0F, 1'b1);
        set_win(3, 4'h0, 8'h20, 8'h00, 1'b1);
        chk("R7 count", dev_count, m_count());
        look("R10 high window hit", 36'h1_0500_0000);
        look("R10 low alias misses", 36'h0_0800_0000);
        look("R8 slot after high window", 36'h0_2000_0000);
        look("R5 miss", 36'h0_3000_0000);

        // R11: lookup in same cycle as write sees old config
        begin
            bit h_old;
            h_old = m_hit(3, 36'h0_2000_0000);
            reg_wr = 1'b1; reg_addr = 6'd28; reg_wdata = 32'd0;
            lk_valid = 1'b1; lk_addr = 36'h0_2000_0000;
            @(negedge clk);
            reg_wr = 1'b0; lk_valid = 1'b0;
            msize[3] = 32'd0;
            chk("R11 old config hit", res_hit, h_old);
            chk("R11 old config cs", res_cs, 3);
            look("R11 new config", 36'h0_2000_0000);
        end

        // R9: results hold while idle
        begin
            logic [7:0] a0;
            a0 = res_attr;
            @(negedge clk);
            chk("R9 valid low", res_valid, 0);
            chk("R9 attr held", res_attr, a0);
        end

        // Random phase (R3 R4 R5 R6 R7 R8 R10)
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < 4; i++)
                set_win(i, ($urandom % 4 == 0) ? 4'($urandom % 2 + 1) : 4'h0,
                        8'($urandom % 16), 8'($urandom % 4), 1'($urandom % 4 != 0));
            chk("R7 random count", dev_count, m_count());
            for (int k = 0; k < 10; k++)
                look("R3 random", {4'($urandom % 4 == 0), 8'($urandom % 24), 24'($urandom)});
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule